// File: doc/BRIEF.md
# Regular-Expression Equivalence Observer

The block runs two regular-expression recognisers side by side and reports, every cycle, whether they agree. Both recognisers see the same start pulse and the same two symbol wires, `a` and `b`. Each recogniser has two outputs. `match` says that some attempt begun by a start pulse has consumed a word of its language. `prefix` says that at least one attempt is still alive. The observer compares the two `prefix` outputs and the two `match` outputs with equality gates. It ANDs the two results into `ok_o`. A sticky `err_o` flag records the first disagreement and holds it until reset.

The recognisers are position automata with one flip-flop per symbol occurrence in the expression. The automaton tables live in a package, so other expression pairs can be swapped in. With `PAIR = 0` the pair is (ab+a)*a against a(ba+a)*. These two languages are equal, so `ok_o` should never drop. With `PAIR = 1` the pair is (ab)*a against a(ba)*b. These languages differ, which serves as a negative control. Comparing `prefix` as well as `match` catches expressions that reject at different times, not only ones that accept different words.

Top module: `regex_equiv_observer`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, every attempt is cleared: both `prefix` outputs and both `match` outputs are 0, `ok_o` is 1 and `err_o` is 0.
- R2: Both recognisers are stepped from the same `start_i`, `sym_a_i` and `sym_b_i` in every cycle.
- R3: A start pulse in cycle t consumes the symbol presented in cycle t. The resulting `match`/`prefix` values appear in cycle t+1. For example, start with `sym_a_i`=1 gives `match`=1 in both recognisers of pair 0 in cycle t+1.
- R4: A symbol wire that is high means that symbol is present. A position advances only when the wire of its own symbol is high. When no live attempt can consume the current symbol, or when both symbol wires are low, `prefix` is 0 in the next cycle. For example, a start on `b` alone leaves `prefix` at 0.
- R5: A start pulse that arrives while an attempt is running adds a new attempt. The running attempt is kept.
- R6: `ok_o` = (prefix_l == prefix_r) AND (match_l == match_r), combinationally, in the same cycle.
- R7: `err_o` rises in the cycle after the first cycle with `ok_o` = 0. It stays 1 until `rst_ni` is driven low.
- R8: With `PAIR = 0`, `ok_o` is 1 in every cycle for every sequence of start pulses and symbols.
- R9: With `PAIR = 1`, a start on the word `a` gives `match_l_o`=1 and `match_r_o`=0 in the next cycle, so `ok_o`=0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new attempt at the current symbol |
| sym_a_i | input | 1 | Symbol `a` present this cycle |
| sym_b_i | input | 1 | Symbol `b` present this cycle |
| match_l_o | output | 1 | Left recogniser has accepted a word |
| prefix_l_o | output | 1 | Left recogniser has a live attempt |
| match_r_o | output | 1 | Right recogniser has accepted a word |
| prefix_r_o | output | 1 | Right recogniser has a live attempt |
| ok_o | output | 1 | Both recognisers agree this cycle |
| err_o | output | 1 | Sticky disagreement flag |

## Verification
A start pulse can arrive in the same cycle in which an earlier attempt consumes its next symbol. The new attempt must then merge into the state without erasing the old one. The bench provokes this by starting on `a` and then asserting `start_i` again together with `b`. It judges the result by requiring `prefix` to stay high after the restart, and `match` to rise one symbol later on the word `aba`. A long pseudo-random run with frequent overlapping starts drives the equivalent pair, and `ok_o` must hold in every cycle. The same stimulus drives the non-equivalent pair, where `err_o` must latch and hold.

// File: rtl/regex_equiv_pkg.sv
package regex_equiv_pkg;
  localparam int unsigned NSYM = 2;  // bit 0 = a, bit 1 = b
  localparam int unsigned SELW = 1;

  // tables: SYM bit per position (0=a,1=b), FIRST/LAST masks,
  // FOLLOW bit i*NPOS+j set when position j may follow position i

  // (ab+a)*a : positions a b a a
  localparam int unsigned  EQ_L_NPOS   = 4;
  localparam logic [3:0]   EQ_L_SYM    = 4'b0010;
  localparam logic [3:0]   EQ_L_FIRST  = 4'b1101;
  localparam logic [3:0]   EQ_L_LAST   = 4'b1000;
  localparam logic [15:0]  EQ_L_FOLLOW = 16'b0000_1101_1101_0010;

  // a(ba+a)* : positions a b a a
  localparam int unsigned  EQ_R_NPOS   = 4;
  localparam logic [3:0]   EQ_R_SYM    = 4'b0010;
  localparam logic [3:0]   EQ_R_FIRST  = 4'b0001;
  localparam logic [3:0]   EQ_R_LAST   = 4'b1101;
  localparam logic [15:0]  EQ_R_FOLLOW = 16'b1010_1010_0100_1010;

  // (ab)*a : positions a b a
  localparam int unsigned  NE_L_NPOS   = 3;
  localparam logic [2:0]   NE_L_SYM    = 3'b010;
  localparam logic [2:0]   NE_L_FIRST  = 3'b101;
  localparam logic [2:0]   NE_L_LAST   = 3'b100;
  localparam logic [8:0]   NE_L_FOLLOW = 9'b000_101_010;

  // a(ba)*b : positions a b a b
  localparam int unsigned  NE_R_NPOS   = 4;
  localparam logic [3:0]   NE_R_SYM    = 4'b1010;
  localparam logic [3:0]   NE_R_FIRST  = 4'b0001;
  localparam logic [3:0]   NE_R_LAST   = 4'b1000;
  localparam logic [15:0]  NE_R_FOLLOW = 16'b0000_1010_0100_1010;
endpackage

// File: rtl/regex_pos_matcher.sv
module regex_pos_matcher #(
  parameter int unsigned NPOS = 4,
  parameter int unsigned NSYM = 2,
  parameter int unsigned SELW = 1,
  parameter logic [NPOS*SELW-1:0] SYM    = '0,
  parameter logic [NPOS-1:0]      FIRST  = '0,
  parameter logic [NPOS-1:0]      LAST   = '0,
  parameter logic [NPOS*NPOS-1:0] FOLLOW = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NSYM-1:0] sym_i,
  output logic            match_o,
  output logic            prefix_o
);
  logic [NPOS-1:0] state_q, state_d;

  for (genvar j = 0; j < NPOS; j++) begin : g_pos
    logic reach;
    always_comb begin
      reach = start_i & FIRST[j];
      for (int i = 0; i < NPOS; i++) reach = reach | (state_q[i] & FOLLOW[i*NPOS+j]);
    end
    assign state_d[j] = reach & sym_i[SYM[j*SELW +: SELW]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign match_o  = |(state_q & LAST);
  assign prefix_o = |state_q;

  // R4: no symbol present kills every attempt
  a_r4_no_symbol_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_i == '0) |=> (state_q == '0));
  // R5: an idle automaton stays idle without a start
  a_r5_idle_without_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && state_q == '0) |=> (state_q == '0));
endmodule

// File: rtl/regex_agree.sv
module regex_agree (
  input  logic prefix_l_i,
  input  logic prefix_r_i,
  input  logic match_l_i,
  input  logic match_r_i,
  output logic ok_o
);
  logic prefix_eq, match_eq;
  assign prefix_eq = ~(prefix_l_i ^ prefix_r_i);
  assign match_eq  = ~(match_l_i ^ match_r_i);
  assign ok_o      = prefix_eq & match_eq;
endmodule

// File: rtl/regex_equiv_observer.sv
module regex_equiv_observer #(
  parameter int unsigned PAIR = 0  // 0: equivalent pair, 1: non-equivalent pair
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sym_a_i,
  input  logic sym_b_i,
  output logic match_l_o,
  output logic prefix_l_o,
  output logic match_r_o,
  output logic prefix_r_o,
  output logic ok_o,
  output logic err_o
);
  import regex_equiv_pkg::*;

  logic [NSYM-1:0] sym;
  logic            err_q;
  assign sym = {sym_b_i, sym_a_i};

  if (PAIR == 0) begin : g_equiv
    regex_pos_matcher #(.NPOS(EQ_L_NPOS), .NSYM(NSYM), .SELW(SELW), .SYM(EQ_L_SYM),
      .FIRST(EQ_L_FIRST), .LAST(EQ_L_LAST), .FOLLOW(EQ_L_FOLLOW)) u_left (
      .clk_i, .rst_ni, .start_i, .sym_i(sym), .match_o(match_l_o), .prefix_o(prefix_l_o));
    regex_pos_matcher #(.NPOS(EQ_R_NPOS), .NSYM(NSYM), .SELW(SELW), .SYM(EQ_R_SYM),
      .FIRST(EQ_R_FIRST), .LAST(EQ_R_LAST), .FOLLOW(EQ_R_FOLLOW)) u_right (
      .clk_i, .rst_ni, .start_i, .sym_i(sym), .match_o(match_r_o), .prefix_o(prefix_r_o));

    // R8: equivalent expressions never disagree
    a_r8_equiv_holds: assert property (@(posedge clk_i) disable iff (!rst_ni) ok_o);
  end else begin : g_nonequiv
    regex_pos_matcher #(.NPOS(NE_L_NPOS), .NSYM(NSYM), .SELW(SELW), .SYM(NE_L_SYM),
      .FIRST(NE_L_FIRST), .LAST(NE_L_LAST), .FOLLOW(NE_L_FOLLOW)) u_left (
      .clk_i, .rst_ni, .start_i, .sym_i(sym), .match_o(match_l_o), .prefix_o(prefix_l_o));
    regex_pos_matcher #(.NPOS(NE_R_NPOS), .NSYM(NSYM), .SELW(SELW), .SYM(NE_R_SYM),
      .FIRST(NE_R_FIRST), .LAST(NE_R_LAST), .FOLLOW(NE_R_FOLLOW)) u_right (
      .clk_i, .rst_ni, .start_i, .sym_i(sym), .match_o(match_r_o), .prefix_o(prefix_r_o));
  end

  regex_agree u_agree (
    .prefix_l_i(prefix_l_o), .prefix_r_i(prefix_r_o),
    .match_l_i(match_l_o),   .match_r_i(match_r_o), .ok_o(ok_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (!ok_o) err_q <= 1'b1;
  end
  assign err_o = err_q;

  a_r7_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni) !ok_o |=> err_o);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> err_o);
endmodule

// File: tb/sim_regex_equiv_observer.sv
`timescale 1ns/1ps
module sim_regex_equiv_observer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sa = 1'b0, sb = 1'b0;
  logic ml0, pl0, mr0, pr0, ok0, err0;
  logic ml1, pl1, mr1, pr1, ok1, err1;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  regex_equiv_observer #(.PAIR(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sym_a_i(sa), .sym_b_i(sb),
    .match_l_o(ml0), .prefix_l_o(pl0), .match_r_o(mr0), .prefix_r_o(pr0),
    .ok_o(ok0), .err_o(err0));
  regex_equiv_observer #(.PAIR(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sym_a_i(sa), .sym_b_i(sb),
    .match_l_o(ml1), .prefix_l_o(pl1), .match_r_o(mr1), .prefix_r_o(pr1),
    .ok_o(ok1), .err_o(err1));

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // drive at negedge, consumed at posedge, sample just after
  task automatic step(input logic s, input logic a, input logic b);
    @(negedge clk);
    start = s; sa = a; sb = b;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; sa = 1'b0; sb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pl0 | pr0 | ml0 | mr0, 1'b0, "R1 u0 outputs cleared in reset");
    chk(ok0, 1'b1, "R1 u0 ok in reset");
    chk(err1, 1'b0, "R1 u1 err in reset");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk(pl1 | pr1 | ml1 | mr1, 1'b0, "R1 u1 outputs idle after reset");
    chk(err0, 1'b0, "R1 u0 err after reset");
  endtask

  task automatic t_word_a();
    do_reset();
    step(1'b1, 1'b1, 1'b0);
    chk(ml0, 1'b1, "R3 u0 left match on a");
    chk(mr0, 1'b1, "R2 u0 right match on a (shared start)");
    chk(pl0 & pr0, 1'b1, "R2 u0 both prefixes live");
    chk(ok0, 1'b1, "R6 u0 ok when agreeing");
    step(1'b0, 1'b0, 1'b1);  // "ab"
    chk(ml0 | mr0, 1'b0, "R3 u0 no match on ab");
    chk(pl0 & pr0, 1'b1, "R4 u0 ab still a live prefix");
    step(1'b0, 1'b1, 1'b0);  // "aba"
    chk(ml0 & mr0, 1'b1, "R3 u0 match on aba");
  endtask

  task automatic t_prefix_drop();
    do_reset();
    step(1'b1, 1'b0, 1'b1);
    chk(pl0 | pr0, 1'b0, "R4 start on b gives no live attempt");
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);  // "ab"
    step(1'b0, 1'b0, 1'b1);  // "abb" dead
    chk(pl0 | pr0, 1'b0, "R4 abb kills both");
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);  // no symbol
    chk(pl0 | pr0 | ml0 | mr0, 1'b0, "R4 empty symbol kills both");
    step(1'b1, 1'b1, 1'b1);  // both wires high: a consumed
    chk(ml0 & mr0, 1'b1, "R4 both wires high serve symbol a");
  endtask

  task automatic t_overlap();
    do_reset();
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);  // restart on b: old attempt must survive
    chk(pl0 & pr0, 1'b1, "R5 old attempt kept across restart");
    chk(pl1, 1'b1, "R5 u1 left old attempt kept");
    step(1'b0, 1'b1, 1'b0);
    chk(ml0 & mr0, 1'b1, "R5 old attempt matches aba");
    chk(ml1, 1'b1, "R5 u1 left matches aba");
  endtask

  task automatic t_bad_pair();
    do_reset();
    step(1'b1, 1'b1, 1'b0);
    chk(ml1, 1'b1, "R9 u1 left matches a");
    chk(mr1, 1'b0, "R9 u1 right rejects a");
    chk(ok1, 1'b0, "R6 u1 ok low on disagreement");
    chk(err1, 1'b0, "R7 err not yet set");
    step(1'b0, 1'b0, 1'b0);
    chk(err1, 1'b1, "R7 err set next cycle");
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk(ok1, 1'b1, "R6 u1 ok back high");
    chk(err1, 1'b1, "R7 err sticky");
    do_reset();
    #1;
    chk(err1, 1'b0, "R7 err cleared by reset");
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    int bad = 0;
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0] == 2'b00, lfsr[5] | lfsr[8], lfsr[6] & ~lfsr[9]);
      if (ok0 !== 1'b1) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R8 ok dropped actual=%0d cycles expected=0", bad);
    end
    chk(err0, 1'b0, "R8 u0 err stays clear");
    chk(err1, 1'b1, "R7 u1 err latched during random run");
  endtask

  initial begin
    t_reset();
    t_word_a();
    t_prefix_drop();
    t_overlap();
    t_bad_pair();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule